// File: doc/BRIEF.md
# Time-Shared Quadratic Evaluator

The block evaluates the polynomial y = A·x² + B·x + C on unsigned operands. It has one multiplier and one adder. A five-state controller steers their inputs through multiplexers so that the same two units compute x·x, then B·x + C, then A·(x·x) added to the stored B·x + C. Intermediate values live in two registers: the square, and the linear term plus constant.

A caller presents x, A, B and C together with a one-cycle (or longer) `go_i` strobe while the block is idle. All four operands are captured on the accepting edge. The result appears on `y_o` together with a one-cycle `done_o` pulse. The result stays on `y_o` until the next evaluation completes. Requests made while an evaluation is running are dropped, not queued. If `go_i` is held high, the block produces one result every five cycles.

Top module: `quad_eval`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first result, `y_o` is 0 and `done_o` is 0.
- R2: When `go_i` is high at a rising edge while the block is idle, that edge accepts a request. `done_o` goes high exactly three cycles after the accepting edge and stays high for one cycle only.
- R3: When `done_o` is high, `y_o` equals A·x² + B·x + C as an exact unsigned value of 3N+1 bits. This holds for all operand values, including all-ones operands.
- R4: Only the operand values present at the accepting edge enter the result. Changing `x_i`, `a_i`, `b_i` or `c_i` after that edge does not alter the result.
- R5: `go_i` has no effect during the four cycles after an accepting edge, including the cycle in which `done_o` is high. It neither restarts nor queues an evaluation.
- R6: `y_o` changes only in a cycle in which `done_o` is high. Between results it holds the last result.
- R7: With `go_i` held high, requests are accepted every fifth cycle, giving one result per five cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start request, accepted only when idle |
| x_i | input | N | Unsigned variable x |
| a_i | input | N | Unsigned coefficient of x² |
| b_i | input | N | Unsigned coefficient of x |
| c_i | input | N | Unsigned constant term |
| y_o | output | 3N+1 | Result register |
| done_o | output | 1 | One-cycle pulse, result valid |

## Verification
On every cycle, the bound checker confirms four things. The done pulse is never longer than one cycle. It lands exactly in the fourth cycle of an accepted evaluation. The result it marks matches the polynomial of the operands captured at acceptance. The result never moves outside a done cycle. Some effects can be seen only through the bench's scenarios: scrambling the operands after acceptance, hammering `go_i` through a busy window and then seeing no extra result, and the back-to-back cadence when `go_i` is held. The bench also covers the reset values and the all-ones and zero operand corners.

// File: rtl/quad_eval_pkg.sv
package quad_eval_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SQ   = 3'd1,
    ST_LIN  = 3'd2,
    ST_QUAD = 3'd3,
    ST_DONE = 3'd4
  } state_e;

  typedef enum logic {MA_X = 1'b0, MA_XX = 1'b1} ma_sel_e;

  typedef enum logic [1:0] {
    MB_X = 2'd0,
    MB_A = 2'd1,
    MB_B = 2'd2
  } mb_sel_e;

  typedef enum logic {AB_C = 1'b0, AB_BXC = 1'b1} ab_sel_e;

  typedef struct packed {
    logic    ld_x;
    logic    ld_xx;
    logic    ld_bxc;
    logic    ld_y;
    ma_sel_e ma_sel;
    mb_sel_e mb_sel;
    ab_sel_e ab_sel;
  } ctl_t;

endpackage

// File: rtl/quad_ctrl.sv
module quad_ctrl
  import quad_eval_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output ctl_t ctl_o,
  output logic done_o
);

  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    ctl_o   = '0;
    done_o  = 1'b0;
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go_i) begin
        ctl_o.ld_x = 1'b1;
        state_d    = ST_SQ;
      end
      ST_SQ: begin
        ctl_o.ma_sel = MA_X;
        ctl_o.mb_sel = MB_X;
        ctl_o.ld_xx  = 1'b1;
        state_d      = ST_LIN;
      end
      ST_LIN: begin
        ctl_o.ma_sel = MA_X;
        ctl_o.mb_sel = MB_B;
        ctl_o.ab_sel = AB_C;
        ctl_o.ld_bxc = 1'b1;
        state_d      = ST_QUAD;
      end
      ST_QUAD: begin
        ctl_o.ma_sel = MA_XX;
        ctl_o.mb_sel = MB_A;
        ctl_o.ab_sel = AB_BXC;
        ctl_o.ld_y   = 1'b1;
        state_d      = ST_DONE;
      end
      ST_DONE: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/quad_datapath.sv
module quad_datapath
  import quad_eval_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctl_t             ctl_i,
  input  logic [N-1:0]     x_i,
  input  logic [N-1:0]     a_i,
  input  logic [N-1:0]     b_i,
  input  logic [N-1:0]     c_i,
  output logic [3*N:0]     y_o
);

  localparam int SW = 2 * N;   // square width
  localparam int PW = 3 * N;   // product width
  localparam int W  = PW + 1;  // result width

  logic [N-1:0]  x_q, a_q, b_q, c_q;
  logic [SW-1:0] xx_q;
  logic [W-1:0]  bxc_q, y_q;

  logic [SW-1:0] mul_a;
  logic [N-1:0]  mul_b;
  logic [PW-1:0] prod;
  logic [W-1:0]  add_b, sum;

  // operand capture on accept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (ctl_i.ld_x) begin
      x_q <= x_i;
      a_q <= a_i;
      b_q <= b_i;
      c_q <= c_i;
    end
  end

  // operand steering
  assign mul_a = (ctl_i.ma_sel == MA_XX) ? xx_q : {{N{1'b0}}, x_q};

  always_comb begin
    case (ctl_i.mb_sel)
      MB_X:    mul_b = x_q;
      MB_A:    mul_b = a_q;
      MB_B:    mul_b = b_q;
      default: mul_b = '0;
    endcase
  end

  assign add_b = (ctl_i.ab_sel == AB_BXC) ? bxc_q : W'(c_q);

  // shared operators
  assign prod = PW'(mul_a) * PW'(mul_b);
  assign sum  = W'(prod) + add_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xx_q  <= '0;
      bxc_q <= '0;
      y_q   <= '0;
    end else begin
      if (ctl_i.ld_xx)  xx_q  <= prod[SW-1:0];
      if (ctl_i.ld_bxc) bxc_q <= sum;
      if (ctl_i.ld_y)   y_q   <= sum;
    end
  end

  assign y_o = y_q;

endmodule

// File: rtl/quad_eval.sv
module quad_eval
  import quad_eval_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] c_i,
  output logic [3*N:0] y_o,
  output logic         done_o
);

  ctl_t ctl;

  quad_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go_i),
    .ctl_o  (ctl),
    .done_o (done_o)
  );

  quad_datapath #(.N(N)) u_dp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl),
    .x_i    (x_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .c_i    (c_i),
    .y_o    (y_o)
  );

endmodule

// File: rtl/quad_eval_chk.sv
module quad_eval_chk #(
  parameter int N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         go_i,
  input logic [N-1:0] x_i,
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic [N-1:0] c_i,
  input logic [3*N:0] y_o,
  input logic         done_o
);

  localparam int W = 3 * N + 1;

  // independent phase tracker: 0 idle, 1..4 busy
  logic [2:0]   ph_q;
  logic [W-1:0] exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= 3'd0;
      exp_q <= '0;
    end else if (ph_q == 3'd0) begin
      if (go_i) begin
        ph_q  <= 3'd1;
        exp_q <= W'(a_i) * W'(x_i) * W'(x_i) + W'(b_i) * W'(x_i) + W'(c_i);
      end
    end else if (ph_q == 3'd4) begin
      ph_q <= 3'd0;
    end else begin
      ph_q <= ph_q + 3'd1;
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == (ph_q == 3'd4));

  p_result_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (y_o == exp_q));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(y_o) |-> done_o);

endmodule

bind quad_eval quad_eval_chk #(.N(N)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .go_i   (go_i),
  .x_i    (x_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .c_i    (c_i),
  .y_o    (y_o),
  .done_o (done_o)
);

// File: tb/quad_eval_bench.sv
module quad_eval_bench;

  localparam int  N          = 8;
  localparam int  W          = 3 * N + 1;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         go;
  logic [N-1:0] x, a, b, c;
  logic [W-1:0] y;
  logic         done;

  int           errors = 0;
  int           checks = 0;
  int           done_seen = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_y = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  quad_eval #(.N(N)) u_quad_eval (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .go_i   (go),
    .x_i    (x),
    .a_i    (a),
    .b_i    (b),
    .c_i    (c),
    .y_o    (y),
    .done_o (done)
  );

  function automatic logic [W-1:0] model(input logic [N-1:0] xv, av, bv, cv);
    return W'(av) * W'(xv) * W'(xv) + W'(bv) * W'(xv) + W'(cv);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on each done pulse
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      done_seen++;
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R5: actual=unexpected result %0d expected=no result pending", y);
      end else begin
        chk("R3 result", y, exp_q.pop_front());
        last_y = y;
      end
    end
  end

  // one evaluation; optional go hammering while busy
  task automatic eval_one(input logic [N-1:0] xv, av, bv, cv, input bit hammer);
    int d0;
    @(negedge clk);
    x = xv; a = av; b = bv; c = cv; go = 1'b1;
    exp_q.push_back(model(xv, av, bv, cv));
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (i == 1) begin
        go = hammer;
        x = ~xv; a = ~av; b = ~bv; c = ~cv;  // R4: scramble after accept
      end
      chk((i == 4) ? "R2 done slot" : "R2 done early", W'(done), W'(i == 4));
    end
    @(negedge clk);
    go = 1'b0;
    chk("R2 single pulse", W'(done), '0);
    if (hammer) begin
      d0 = done_seen;
      repeat (6) @(negedge clk);
      chk("R5 no extra result", W'(done_seen - d0), '0);
    end
  endtask

  task automatic stream(input int n);
    int d0;
    d0 = done_seen;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      x = N'(17 * k + 3); a = N'(29 * k + 250); b = N'(7 * k + 1); c = N'(200 - k);
      go = 1'b1;
      exp_q.push_back(model(x, a, b, c));
      repeat (5) @(negedge clk);
    end
    go = 1'b0;
    chk("R7 one result per five cycles", W'(done_seen - d0), W'(n));
    chk("R7 scoreboard drained", W'(exp_q.size()), '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; go = 1'b0; x = '0; a = '0; b = '0; c = '0;
    repeat (3) @(negedge clk);
    chk("R1 y in reset", y, '0);
    chk("R1 done in reset", W'(done), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 y after release", y, '0);

    eval_one(8'd3, 8'd2, 8'd5, 8'd7, 1'b0);     // R3 R4 basic
    eval_one(8'd0, 8'd99, 8'd44, 8'd123, 1'b0); // R3 x zero -> C
    eval_one(8'd255, 8'd255, 8'd255, 8'd255, 1'b0); // R3 all ones
    eval_one(8'd12, 8'd0, 8'd0, 8'd0, 1'b1);    // R5 hammer go, zero result
    eval_one(8'd200, 8'd1, 8'd128, 8'd9, 1'b1); // R5 hammer go

    // R6: result holds while inputs move and go stays low
    x = 8'd77; a = 8'd66; b = 8'd55; c = 8'd44;
    repeat (4) @(negedge clk);
    chk("R6 hold", y, model(8'd200, 8'd1, 8'd128, 8'd9));
    chk("R6 hold last", y, last_y);

    stream(4);                                  // R7 back-to-back
    repeat (3) @(negedge clk);
    chk("R6 hold after stream", y, last_y);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule